// File: doc/BRIEF.md
# Comma Detect Word Aligner

This block sits behind a deserializer that delivers unaligned 10-bit chunks of a line-coded stream, one chunk per clock, with chunk bit 0 being the earliest bit received. It looks for the positive-polarity comma pattern at every bit offset of the recent stream. The first bit of a matching pattern becomes the word boundary, and from then on the block delivers aligned 10-bit words together with a flag that marks comma words.

Framing is controlled by an enable input. With the enable low, no boundary search takes place, chunks pass through unchanged and the flag is held low. A rate-mode input selects between a word-rate output clock and a pair of complementary half-rate output clocks. The clocks are presented as per-cycle phase levels. In the half-rate-clock mode, the phase of the primary clock is steered by stretching one low phase, so that the first comma of a run is presented while the primary clock has just risen. Runs of back-to-back commas do not disturb the clocks.

Top module: `comma_aligner`

## Requirements
- R1: A word is a comma when its bits 0..6 are 0,0,1,1,1,1,1, which is the value 7'b1111100 on word[6:0]. Bits 7..9 are ignored. The negative-polarity form, with bits 0..6 equal to 1,1,0,0,0,0,0, is never matched.
- R2: With framing enabled, a comma that starts at any of the 10 bit offsets sets the word boundary. The comma word appears on `word_out` with bit 0 being its first received bit. A word whose first bit is stream bit 10*j+k, counting from the first chunk driven, is on the output after the clock edge that samples chunk j+4 (counting edges from 0).
- R3: After alignment, the words that follow the comma appear on consecutive cycles at the same boundary.
- R4: If the current boundary offset holds a comma, the boundary is kept even when other offsets match as well. Otherwise the lowest matching offset, which is the earliest received, is taken.
- R5: With framing disabled, the offset is forced to 0, and chunk c appears unchanged on `word_out` after edge c+4.
- R6: `comma_det` is high only in cycles where framing is enabled and a comma word is on `word_out`.
- R7: `comma_det` goes low from the first edge at which the enable is sampled low. After the enable is sampled high, a comma already in flight is flagged no later than the third edge.
- R8: With `half_clk_mode` = 1, `clk_pri_ph` and `clk_sec_ph` are complementary. The primary clock is never high for 2 cycles in a row and never low for more than 2 cycles in a row. The first comma of a run is output in a cycle in which `clk_pri_ph` is 1 and was 0 in the cycle before.
- R9: Back-to-back comma words keep `comma_det` high for each of them, and `clk_pri_ph` toggles every cycle with no stretched phase.
- R10: With `half_clk_mode` = 0 (word-rate clock), `clk_pri_ph` is held at 1 and `clk_sec_ph` at 0.
- R11: During reset, `word_out` = 0, `comma_det` = 0, `clk_pri_ph` = 0, `clk_sec_ph` = 1, and the boundary offset is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_chunk | input | 10 | Unaligned chunk; bit 0 is the earliest received |
| frame_en | input | 1 | Enables comma search and framing |
| half_clk_mode | input | 1 | 1 selects the complementary half-rate output clocks |
| word_out | output | 10 | Aligned word; bit 0 is the first received |
| comma_det | output | 1 | High while a comma word is on `word_out` |
| clk_pri_ph | output | 1 | Level of the primary output clock in this cycle |
| clk_sec_ph | output | 1 | Level of the secondary output clock in this cycle |

## Verification
A chunk passes through four registers on its way to the output: the window and match stage, the aligned-word stage, the phase look-ahead stage and the output register. The bench therefore drives chunk j before edge j, records the outputs half a cycle after each edge, and expects the word that starts at stream bit 10*j+k in record j+4. An enable change applied before edge m shows up as a low flag in record m, and as a raised flag no later than record m+2. Phase checks run over the recorded trace. They look for the low-to-high step in the cycle just before each first comma and for bounded run lengths of the primary level.

// File: rtl/comma_align_pkg.sv
package comma_align_pkg;

    localparam int WORD_W = 10;
    localparam int PAT_W  = 7;
    localparam logic [PAT_W-1:0] PAT_CODE = 7'b1111100;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              comma;
    } lane_t;

endpackage

// File: rtl/comma_scan.sv
module comma_scan
    import comma_align_pkg::*;
#(
    parameter int W = WORD_W,
    parameter int P = PAT_W,
    parameter logic [P-1:0] CODE = PAT_CODE,
    localparam int WIN = 2 * W - 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [W-1:0]   raw_chunk,
    output logic [WIN-1:0] win_q,
    output logic [W-1:0]   hit_q
);

    logic [W-1:0]   chunk_q;
    logic [WIN-1:0] window;
    logic [W-1:0]   match;

    assign window = {raw_chunk[W-2:0], chunk_q};

    for (genvar k = 0; k < W; k++) begin : g_off
        assign match[k] = (window[k +: P] == CODE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chunk_q <= '0;
            win_q   <= '0;
            hit_q   <= '0;
        end else begin
            chunk_q <= raw_chunk;
            win_q   <= window;
            hit_q   <= match;
        end
    end

endmodule

// File: rtl/offset_ctrl.sv
module offset_ctrl
    import comma_align_pkg::*;
#(
    parameter int W = WORD_W,
    localparam int OW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  hit_q,
    input  logic          frame_en,
    output logic [OW-1:0] off_use,
    output logic          use_comma
);

    logic [OW-1:0] cur_off;
    logic [OW-1:0] low;

    always_comb begin
        low = '0;
        for (int k = W - 1; k >= 0; k--) begin
            if (hit_q[k]) low = OW'(k);
        end
        if (!frame_en) begin
            off_use   = '0;
            use_comma = 1'b0;
        end else if (hit_q[cur_off]) begin
            off_use   = cur_off;
            use_comma = 1'b1;
        end else if (|hit_q) begin
            off_use   = low;
            use_comma = 1'b1;
        end else begin
            off_use   = cur_off;
            use_comma = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur_off <= '0;
        else     cur_off <= off_use;
    end

    // R4: a comma at the held offset never moves the boundary
    a_r4_keep_offset: assert property (@(posedge clk) disable iff (rst)
        (frame_en && hit_q[cur_off]) |=> (cur_off == $past(cur_off)));

    // R5: framing off returns the boundary to offset 0
    a_r5_unframed_zero: assert property (@(posedge clk) disable iff (rst)
        !frame_en |=> (cur_off == '0));

    // R2: the boundary stays inside the word
    a_r2_offset_range: assert property (@(posedge clk) disable iff (rst)
        32'(cur_off) < W);

endmodule

// File: rtl/word_shifter.sv
module word_shifter
    import comma_align_pkg::*;
#(
    parameter int W = WORD_W,
    parameter int P = PAT_W,
    parameter logic [P-1:0] CODE = PAT_CODE,
    localparam int OW  = $clog2(W),
    localparam int WIN = 2 * W - 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [WIN-1:0] win_q,
    input  logic [OW-1:0]  off_use,
    input  logic           use_comma,
    output lane_t          a_q
);

    logic [W-1:0] cand [W];
    logic [W-1:0] ext;

    for (genvar k = 0; k < W; k++) begin : g_cand
        assign cand[k] = win_q[k +: W];
    end

    assign ext = cand[off_use];

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
        end else begin
            a_q.data  <= ext;
            a_q.comma <= use_comma;
        end
    end

    // R1: a word marked as comma carries the comma pattern
    a_r1_marked_is_comma: assert property (@(posedge clk) disable iff (rst)
        a_q.comma |-> (a_q.data[P-1:0] == CODE));

endmodule

// File: rtl/phase_gen.sv
module phase_gen
    import comma_align_pkg::*;
#(
    parameter int W = WORD_W,
    parameter int P = PAT_W,
    parameter logic [P-1:0] CODE = PAT_CODE
) (
    input  logic         clk,
    input  logic         rst,
    input  lane_t        a_q,
    input  logic         frame_en,
    input  logic         half_clk_mode,
    output logic [W-1:0] word_out,
    output logic         comma_det,
    output logic         clk_pri_ph,
    output logic         clk_sec_ph
);

    lane_t b_q;
    logic  a_hit;
    logic  pri_nxt;

    assign a_hit = a_q.comma & frame_en;

    always_comb begin
        if (!half_clk_mode)
            pri_nxt = 1'b1;
        else if (a_hit && !b_q.comma && !clk_pri_ph)
            pri_nxt = 1'b0;
        else
            pri_nxt = !clk_pri_ph;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            b_q        <= '0;
            word_out   <= '0;
            comma_det  <= 1'b0;
            clk_pri_ph <= 1'b0;
            clk_sec_ph <= 1'b1;
        end else begin
            b_q.data   <= a_q.data;
            b_q.comma  <= a_hit;
            word_out   <= b_q.data;
            comma_det  <= b_q.comma & frame_en;
            clk_pri_ph <= pri_nxt;
            clk_sec_ph <= half_clk_mode ? !pri_nxt : 1'b0;
        end
    end

    // R6: the flag only stands beside a comma word
    a_r6_flag_on_comma: assert property (@(posedge clk) disable iff (rst)
        comma_det |-> (word_out[P-1:0] == CODE));

    // R7: enable low clears the flag at the next edge
    a_r7_enable_off: assert property (@(posedge clk) disable iff (rst)
        !frame_en |=> !comma_det);

    // R8: the two half-rate clocks are complementary
    a_r8_complement: assert property (@(posedge clk) disable iff (rst)
        half_clk_mode |=> (clk_sec_ph == !clk_pri_ph));

    // R8: the first comma of a run coincides with a primary rising step
    a_r8_comma_on_rise: assert property (@(posedge clk) disable iff (rst)
        ($past(half_clk_mode) && $past(half_clk_mode, 2) && $rose(comma_det))
        |-> (clk_pri_ph && !$past(clk_pri_ph)));

    // R9: a comma continuing a run never stretches a phase
    a_r9_b2b_toggle: assert property (@(posedge clk) disable iff (rst)
        ($past(half_clk_mode) && comma_det) |-> (clk_pri_ph != $past(clk_pri_ph)));

    // R10: word-rate mode holds the clock levels fixed
    a_r10_word_rate: assert property (@(posedge clk) disable iff (rst)
        !half_clk_mode |=> (clk_pri_ph && !clk_sec_ph));

endmodule

// File: rtl/comma_aligner.sv
module comma_aligner
    import comma_align_pkg::*;
#(
    parameter int W = WORD_W,
    parameter int P = PAT_W,
    parameter logic [P-1:0] CODE = PAT_CODE,
    localparam int OW  = $clog2(W),
    localparam int WIN = 2 * W - 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw_chunk,
    input  logic         frame_en,
    input  logic         half_clk_mode,
    output logic [W-1:0] word_out,
    output logic         comma_det,
    output logic         clk_pri_ph,
    output logic         clk_sec_ph
);

    logic [WIN-1:0] win_q;
    logic [W-1:0]   hit_q;
    logic [OW-1:0]  off_use;
    logic           use_comma;
    lane_t          a_q;

    comma_scan #(.W(W), .P(P), .CODE(CODE)) u_scan (
        .clk       (clk),
        .rst       (rst),
        .raw_chunk (raw_chunk),
        .win_q     (win_q),
        .hit_q     (hit_q)
    );

    offset_ctrl #(.W(W)) u_off (
        .clk       (clk),
        .rst       (rst),
        .hit_q     (hit_q),
        .frame_en  (frame_en),
        .off_use   (off_use),
        .use_comma (use_comma)
    );

    word_shifter #(.W(W), .P(P), .CODE(CODE)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .win_q     (win_q),
        .off_use   (off_use),
        .use_comma (use_comma),
        .a_q       (a_q)
    );

    phase_gen #(.W(W), .P(P), .CODE(CODE)) u_phase (
        .clk           (clk),
        .rst           (rst),
        .a_q           (a_q),
        .frame_en      (frame_en),
        .half_clk_mode (half_clk_mode),
        .word_out      (word_out),
        .comma_det     (comma_det),
        .clk_pri_ph    (clk_pri_ph),
        .clk_sec_ph    (clk_sec_ph)
    );

endmodule

// File: tb/comma_aligner_bench.sv
`timescale 1ns/1ps
module comma_aligner_bench;

    localparam logic [9:0] POS_COMMA = 10'h17C;
    localparam logic [9:0] ALT_COMMA = 10'h07C;
    localparam logic [9:0] NEG_COMMA = 10'h283;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] raw_chunk = '0;
    logic       frame_en = 1'b1;
    logic       half_clk_mode = 1'b0;
    logic [9:0] word_out;
    logic       comma_det;
    logic       clk_pri_ph;
    logic       clk_sec_ph;

    int checks = 0;
    int errors = 0;

    logic [399:0] sbits;
    logic [9:0]   fill [6] = '{10'h155, 10'h2AA, 10'h133, 10'h0CC, 10'h249, 10'h1B6};
    logic [9:0]   rec_w [40];
    logic         rec_f [40];
    logic         rec_p [40];
    logic         rec_s [40];

    comma_aligner u_comma_aligner (
        .clk           (clk),
        .rst           (rst),
        .raw_chunk     (raw_chunk),
        .frame_en      (frame_en),
        .half_clk_mode (half_clk_mode),
        .word_out      (word_out),
        .comma_det     (comma_det),
        .clk_pri_ph    (clk_pri_ph),
        .clk_sec_ph    (clk_sec_ph)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic junk();
        for (int i = 0; i < 400; i++) sbits[i] = (i % 2) == 1;
    endtask

    task automatic place(input int pos, input logic [9:0] w);
        sbits[pos +: 10] = w;
    endtask

    function automatic logic [9:0] exp_w(input int n, input int k);
        return sbits[10 * (n - 4) + k +: 10];
    endfunction

    task automatic do_reset(input logic en, input logic half);
        rst = 1'b1;
        frame_en = en;
        half_clk_mode = half;
        raw_chunk = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run(input int n, input int m, input logic en_after);
        for (int j = 0; j < n; j++) begin
            if (j == m) frame_en = en_after;
            raw_chunk = sbits[10 * j +: 10];
            @(posedge clk);
            @(negedge clk);
            rec_w[j] = word_out;
            rec_f[j] = comma_det;
            rec_p[j] = clk_pri_ph;
            rec_s[j] = clk_sec_ph;
        end
    endtask

    task automatic stream_at(input int k);
        junk();
        place(k, POS_COMMA);
        for (int i = 1; i < 6; i++) place(k + 10 * i, fill[i]);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11 word", int'(word_out), 0);
        chk("R11 flag", int'(comma_det), 0);
        chk("R11 pri", int'(clk_pri_ph), 0);
        chk("R11 sec", int'(clk_sec_ph), 1);
        rst = 1'b0;
    endtask

    task automatic t_offsets(input int k);
        do_reset(1'b1, 1'b0);
        stream_at(k);
        run(12, -1, 1'b1);
        chk("R2 comma word", int'(rec_w[4]), int'(POS_COMMA));
        chk("R2 comma flag", int'(rec_f[4]), 1);
        for (int i = 1; i < 6; i++)
            chk("R3 following word", int'(rec_w[4 + i]), int'(fill[i]));
        chk("R6 flag low on data", int'(rec_f[5]), 0);
        chk("R10 pri held", int'(rec_p[6]), 1);
        chk("R10 sec held", int'(rec_s[6]), 0);
    endtask

    task automatic t_negative();
        do_reset(1'b1, 1'b0);
        junk();
        place(4, NEG_COMMA);
        for (int i = 1; i < 6; i++) place(4 + 10 * i, fill[i]);
        run(12, -1, 1'b1);
        for (int n = 4; n < 12; n++)
            chk("R1 negative form not flagged", int'(rec_f[n]), 0);
        chk("R1 boundary untouched", int'(rec_w[6]), int'(exp_w(6, 0)));
    endtask

    task automatic pair_stream();
        junk();
        place(10, ALT_COMMA);
        place(18, POS_COMMA);
        for (int i = 0; i < 4; i++) place(28 + 10 * i, fill[i]);
    endtask

    task automatic t_keep();
        do_reset(1'b1, 1'b0);
        stream_at(8);
        run(12, -1, 1'b1);
        pair_stream();
        run(10, -1, 1'b1);
        chk("R4 keep current offset word", int'(rec_w[5]), int'(POS_COMMA));
        chk("R4 keep current offset flag", int'(rec_f[5]), 1);
        chk("R4 keep next word", int'(rec_w[6]), int'(fill[0]));
    endtask

    task automatic t_lowest();
        do_reset(1'b1, 1'b0);
        stream_at(5);
        run(12, -1, 1'b1);
        pair_stream();
        run(10, -1, 1'b1);
        chk("R4 lowest offset word", int'(rec_w[5]), int'(ALT_COMMA));
        chk("R4 lowest offset flag", int'(rec_f[5]), 1);
        chk("R4 lowest next word", int'(rec_w[6]), int'(exp_w(6, 0)));
    endtask

    task automatic t_disable();
        do_reset(1'b1, 1'b0);
        stream_at(3);
        run(12, -1, 1'b1);
        junk();
        for (int i = 0; i < 8; i++) place(3 + 10 * i, fill[i % 6]);
        place(23, POS_COMMA);
        run(12, 0, 1'b0);
        for (int n = 4; n < 12; n++)
            chk("R5 unframed pass", int'(rec_w[n]), int'(exp_w(n, 0)));
        chk("R6 flag held low", int'(rec_f[6]), 0);
        frame_en = 1'b1;
    endtask

    task automatic t_enable_edges();
        do_reset(1'b0, 1'b0);
        for (int i = 0; i < 40; i++) sbits[10 * i +: 10] = POS_COMMA;
        run(20, 6, 1'b1);
        chk("R7 flag low before enable", int'(rec_f[5]), 0);
        chk("R7 flag by third edge", int'(rec_f[8]), 1);
        run(20, 6, 1'b0);
        chk("R7 flag high before disable", int'(rec_f[5]), 1);
        chk("R7 flag low at first edge", int'(rec_f[6]), 0);
        chk("R7 flag stays low", int'(rec_f[9]), 0);
        frame_en = 1'b1;
    endtask

    task automatic phase_scan(input int n);
        int bad_c = 0;
        int bad_h = 0;
        int bad_l = 0;
        for (int t = 1; t < n; t++) begin
            if (rec_s[t] == rec_p[t]) bad_c++;
            if (rec_p[t] && rec_p[t - 1]) bad_h++;
            if (t >= 2 && !rec_p[t] && !rec_p[t - 1] && !rec_p[t - 2]) bad_l++;
        end
        chk("R8 complementary clocks", bad_c, 0);
        chk("R8 high phase length", bad_h, 0);
        chk("R8 low phase length", bad_l, 0);
    endtask

    task automatic t_full_rate(input int idx);
        do_reset(1'b1, 1'b1);
        junk();
        for (int i = 0; i < 10; i++) place(6 + 10 * i, fill[i % 6]);
        place(6 + 10 * idx, POS_COMMA);
        run(14, -1, 1'b1);
        chk("R8 comma on output", int'(rec_w[idx + 4]), int'(POS_COMMA));
        chk("R8 pri high at comma", int'(rec_p[idx + 4]), 1);
        chk("R8 pri low before comma", int'(rec_p[idx + 3]), 0);
        phase_scan(14);
    endtask

    task automatic t_back_to_back();
        do_reset(1'b1, 1'b1);
        junk();
        for (int i = 0; i < 10; i++) place(1 + 10 * i, fill[i % 6]);
        for (int i = 2; i < 6; i++) place(1 + 10 * i, POS_COMMA);
        run(14, -1, 1'b1);
        for (int n = 6; n < 10; n++)
            chk("R9 flag stays high", int'(rec_f[n]), 1);
        chk("R9 first comma on rise", int'(rec_p[6]), 1);
        for (int n = 7; n < 10; n++)
            chk("R9 pri toggles", int'(rec_p[n]), int'(!rec_p[n - 1]));
        phase_scan(14);
    endtask

    initial begin
        t_reset();
        t_offsets(0);
        t_offsets(3);
        t_offsets(9);
        t_negative();
        t_keep();
        t_lowest();
        t_disable();
        t_enable_edges();
        t_full_rate(2);
        t_full_rate(3);
        t_back_to_back();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule